// File: doc/BRIEF.md
# Interrupt Pending and Enable Controller

This block gathers interrupt events for an audio controller and turns them into one level interrupt for the host. Single-cycle event strobes from the block's sources are latched into a 32-bit pending word, where they stay until the host writes a 1 to clear them. A 32-bit enable word decides which latched events reach the interrupt line. One enable bit forces the line high whatever is pending.

A second group tracks 64 per-channel loop interrupts. Each channel has its own pending bit and its own enable bit, and both are split into a low word (channels 0 to 31) and a high word (channels 32 to 63). The pending word summarises this group in its low seven bits: a summary flag, and the number of the highest channel that has a loop interrupt pending. The host can clear one channel by writing the summary flag together with that channel's number. It can also clear any set of channels through the loop pending words.

The host reaches all state through a simple register port. A write strobe, an address and write data take effect at the clock edge. Read data is a combinational function of the address.

Top module: `irqAggregator`

## Requirements
- R1: After reset every register reads 0 and `irqOut` is low.
- R2: A 1 on `evtStrobe[k]` for k in 7..31 sets pending bit k at the next clock edge. Strobes on bits 6..0 have no effect.
- R3: The pending word is at address 0. Writing it clears each event bit k (7..31) whose write-data bit is 1 and leaves the others unchanged. Write-data bits 6..0 clear no event bit.
- R4: If an event and a host clear hit the same pending bit in the same cycle, the bit ends up set. This holds for event bits and for channel loop bits.
- R5: Pending bit 6 reads 1 exactly when at least one channel loop pending bit is set. Bits 5..0 then read the highest such channel number, and read 0 when none is set.
- R6: A write to address 0 with data bit 6 set clears the loop pending bit of the channel numbered by data bits 5..0, and only that channel's bit.
- R7: The enable word is read/write at address 1. Loop enables are at address 2 (channel i at bit i) and address 3 (channel 32+i at bit i). Loop pending bits are at addresses 4 and 5 in the same layout and are cleared by writing 1s. `loopEvt[c]` sets the loop pending bit of channel c. Addresses 6 and 7 read 0 and ignore writes.
- R8: `irqOut` is high when an enabled event bit is pending or an enabled channel loop bit is pending. Enable bit e gates these pending bits: e0:p7, e1:p8, e2:p9, e3:p10, e4:p11, e5:p12 and p13, e6:p14 and p15, e7:p16 and p17, e8:p18, e9:p19, e10:p20, e11:p21, e12:p23, e13:p24. Pending bits 22 and 25..31 latch but never raise `irqOut`.
- R9: While enable bit 20 is 1, `irqOut` is high whatever the pending state.
- R10: Read data follows `regAddr` in the same cycle. A write or event shows on the read data and on `irqOut` from the clock edge that takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |
| evtStrobe | input | 32 | Event strobes, one per pending bit |
| loopEvt | input | 64 | Per-channel loop event strobes |
| irqOut | output | 1 | Level interrupt output |

## Verification
The bench goes after four corner cases.

- **Event against clear.** A clear that lands in the same cycle as an event must leave the bit set. A design where the clear wins would silently drop an interrupt.
- **Highest-channel encode.** The bench sets channels 3, 40 and 63 and removes them one at a time. An encoder that picks the lowest channel, or that keeps a stale number once the group is empty, shows up as a wrong low field.
- **Single-channel clear.** This is checked against the word clears. A decode that clears the wrong channel, or every channel in the half, leaves the wrong summary behind.
- **Enable mapping and force bit.** Unmapped pending bits are set with every other enable on, and the force bit is set with nothing pending. A wrong map raises or loses `irqOut`.

Long random runs with sparse events and mixed writes cover the rest against a reference model.

// File: rtl/irqAggPkg.sv
package irqAggPkg;
  localparam int SUM_BIT   = 6;
  localparam int FORCE_BIT = 20;
  localparam int EV_LOW    = 7;

  localparam logic [2:0] A_PEND     = 3'd0;
  localparam logic [2:0] A_EN       = 3'd1;
  localparam logic [2:0] A_LOOPEN   = 3'd2;
  localparam logic [2:0] A_LOOPPEND = 3'd4;

  typedef struct packed {
    logic       wrPend;
    logic       wrEn;
    logic [1:0] wrLoopEn;
    logic [1:0] wrLoopPend;
    logic       chanClr;
  } ctrlStb_t;

  // Enable bit that gates a given pending bit, or -1 when none does.
  function automatic int enMapOf(input int p);
    case (p)
      7:       return 0;
      8:       return 1;
      9:       return 2;
      10:      return 3;
      11:      return 4;
      12, 13:  return 5;
      14, 15:  return 6;
      16, 17:  return 7;
      18:      return 8;
      19:      return 9;
      20:      return 10;
      21:      return 11;
      23:      return 12;
      24:      return 13;
      default: return -1;
    endcase
  endfunction
endpackage

// File: rtl/irqAggCtrl.sv
module irqAggCtrl
  import irqAggPkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int HALVES = 2
) (
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              sumBit,
  output ctrlStb_t          stb
);
  always_comb begin
    stb = '0;
    if (regWe) begin
      if (regAddr == ADDR_W'(A_PEND)) begin
        stb.wrPend  = 1'b1;
        stb.chanClr = sumBit;
      end
      if (regAddr == ADDR_W'(A_EN)) stb.wrEn = 1'b1;
      for (int h = 0; h < HALVES; h++) begin
        if (regAddr == ADDR_W'(32'(A_LOOPEN) + 32'(h)))   stb.wrLoopEn[h]   = 1'b1;
        if (regAddr == ADDR_W'(32'(A_LOOPPEND) + 32'(h))) stb.wrLoopPend[h] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irqAggDatapath.sv
module irqAggDatapath
  import irqAggPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_CH = 64,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] evtStrobe,
  input  logic [NUM_CH-1:0] loopEvt,
  output logic [DATA_W-1:0] rdata,
  output logic              irqOut
);
  localparam int CH_W   = $clog2(NUM_CH);
  localparam int HALVES = NUM_CH / DATA_W;
  localparam logic [DATA_W-1:0] EV_MASK = ~DATA_W'((64'd1 << EV_LOW) - 64'd1);

  logic [DATA_W-1:0] evPend, enReg, evClr, pendGate, pendView;
  logic [NUM_CH-1:0] loopPend, loopEn, loopClr;
  logic [CH_W-1:0]   topCh;
  logic              anyLoop;

  // Route each pending bit to the enable bit that gates it.
  for (genvar p = 0; p < DATA_W; p++) begin : g_gate
    if (enMapOf(p) >= 0) begin : g_on
      assign pendGate[p] = enReg[enMapOf(p)];
    end else begin : g_off
      assign pendGate[p] = 1'b0;
    end
  end

  assign evClr = stb.wrPend ? (wdata & EV_MASK) : '0;

  always_comb begin
    loopClr = '0;
    for (int h = 0; h < HALVES; h++)
      if (stb.wrLoopPend[h]) loopClr[h*DATA_W +: DATA_W] = wdata;
    if (stb.chanClr) loopClr[wdata[CH_W-1:0]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evPend   <= '0;
      enReg    <= '0;
      loopPend <= '0;
    end else begin
      evPend   <= (evPend & ~evClr) | (evtStrobe & EV_MASK);
      loopPend <= (loopPend & ~loopClr) | loopEvt;
      if (stb.wrEn) enReg <= wdata;
    end
  end

  for (genvar h = 0; h < HALVES; h++) begin : g_loopEn
    always_ff @(posedge clk) begin
      if (!rstN) loopEn[h*DATA_W +: DATA_W] <= '0;
      else if (stb.wrLoopEn[h]) loopEn[h*DATA_W +: DATA_W] <= wdata;
    end
  end

  // Highest pending channel: later indices overwrite earlier ones.
  always_comb begin
    topCh = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (loopPend[i]) topCh = CH_W'(i);
  end
  assign anyLoop = |loopPend;

  always_comb begin
    pendView = evPend & EV_MASK;
    pendView[SUM_BIT] = anyLoop;
    pendView[CH_W-1:0] = anyLoop ? topCh : '0;
  end

  always_comb begin
    rdata = '0;
    if (rdAddr == ADDR_W'(A_PEND)) rdata = pendView;
    if (rdAddr == ADDR_W'(A_EN))   rdata = enReg;
    for (int h = 0; h < HALVES; h++) begin
      if (rdAddr == ADDR_W'(32'(A_LOOPEN) + 32'(h)))   rdata = loopEn[h*DATA_W +: DATA_W];
      if (rdAddr == ADDR_W'(32'(A_LOOPPEND) + 32'(h))) rdata = loopPend[h*DATA_W +: DATA_W];
    end
  end

  assign irqOut = enReg[FORCE_BIT] | (|(evPend & EV_MASK & pendGate)) | (|(loopPend & loopEn));

  a_r2_event_latch: assert property (@(posedge clk) disable iff (!rstN)
    (|(evtStrobe & EV_MASK)) |=> ((evPend & $past(evtStrobe & EV_MASK)) == $past(evtStrobe & EV_MASK)));

  a_r3_w1c_clear: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrPend && ((evtStrobe & EV_MASK) == '0)) |=> ((evPend & $past(wdata & EV_MASK)) == '0));

  a_r5_top_valid: assert property (@(posedge clk) disable iff (!rstN)
    anyLoop |-> loopPend[topCh]);

  a_r6_chan_clear: assert property (@(posedge clk) disable iff (!rstN)
    (stb.chanClr && !loopEvt[wdata[CH_W-1:0]]) |=> !loopPend[$past(wdata[CH_W-1:0])]);

  a_r9_force: assert property (@(posedge clk) disable iff (!rstN)
    enReg[FORCE_BIT] |-> irqOut);
endmodule

// File: rtl/irqAggregator.sv
module irqAggregator
  import irqAggPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_CH = 64,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic [DATA_W-1:0] evtStrobe,
  input  logic [NUM_CH-1:0] loopEvt,
  output logic              irqOut
);
  localparam int HALVES = NUM_CH / DATA_W;

  ctrlStb_t stb;

  irqAggCtrl #(.ADDR_W(ADDR_W), .HALVES(HALVES)) u_ctrl (
    .regWe  (regWe),
    .regAddr(regAddr),
    .sumBit (regWdata[SUM_BIT]),
    .stb    (stb)
  );

  irqAggDatapath #(.DATA_W(DATA_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wdata    (regWdata),
    .rdAddr   (regAddr),
    .evtStrobe(evtStrobe),
    .loopEvt  (loopEvt),
    .rdata    (regRdata),
    .irqOut   (irqOut)
  );

  a_r7_idle_addr: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr >= ADDR_W'(6)) |-> (regRdata == '0));
endmodule

// File: tb/irqAggregator_tb.sv
module irqAggregator_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [31:0] evtStrobe = '0;
  logic [63:0] loopEvt = '0;
  logic        irqOut;

  always #5 clk = ~clk;

  irqAggregator u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .evtStrobe(evtStrobe),
    .loopEvt(loopEvt), .irqOut(irqOut)
  );

  int errs = 0;
  int checks = 0;
  logic [31:0] mPend = '0, mEn = '0;
  logic [63:0] mLoopEn = '0, mLoopPend = '0;

  function automatic int gateOf(input int p);
    case (p)
      7: return 0;  8: return 1;  9: return 2;  10: return 3;  11: return 4;
      12: return 5; 13: return 5; 14: return 6; 15: return 6; 16: return 7;
      17: return 7; 18: return 8; 19: return 9; 20: return 10; 21: return 11;
      23: return 12; 24: return 13;
      default: return -1;
    endcase
  endfunction

  function automatic logic expIrq();
    logic r = mEn[20] | (|(mLoopPend & mLoopEn));
    for (int p = 7; p < 32; p++)
      if (gateOf(p) >= 0 && mPend[p] && mEn[gateOf(p)]) r = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] expRead(input int a);
    logic [31:0] v = '0;
    int hi = 0;
    case (a)
      0: begin
        v = mPend;
        for (int c = 0; c < 64; c++) if (mLoopPend[c]) hi = c;
        if (mLoopPend != '0) begin v[6] = 1'b1; v[5:0] = 6'(hi); end
      end
      1: v = mEn;
      2: v = mLoopEn[31:0];
      3: v = mLoopEn[63:32];
      4: v = mLoopPend[31:0];
      5: v = mLoopPend[63:32];
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkRead(input int a, input string tag);
    regAddr = 3'(a);
    #1;
    chk(tag, regRdata, expRead(a));
  endtask

  task automatic checkAll(input string tag);
    for (int a = 0; a < 8; a++) checkRead(a, tag);
  endtask

  // One clock: drive at the falling edge, update the model at the rising edge,
  // then return the inputs to idle and check the interrupt line.
  task automatic doCycle(input logic we, input int a, input logic [31:0] wd,
                         input logic [31:0] ev, input logic [63:0] lp, input string tag);
    @(negedge clk);
    regWe = we; regAddr = 3'(a); regWdata = wd; evtStrobe = ev; loopEvt = lp;
    @(posedge clk);
    if (we) begin
      case (a)
        0: begin
          mPend &= ~(wd & 32'hFFFF_FF80);
          if (wd[6]) mLoopPend[wd[5:0]] = 1'b0;
        end
        1: mEn = wd;
        2: mLoopEn[31:0] = wd;
        3: mLoopEn[63:32] = wd;
        4: mLoopPend[31:0] &= ~wd;
        5: mLoopPend[63:32] &= ~wd;
        default: ;
      endcase
    end
    mPend |= ev & 32'hFFFF_FF80;
    mLoopPend |= lp;
    #1;
    regWe = 1'b0; evtStrobe = '0; loopEvt = '0;
    chk(tag, 32'(irqOut), 32'(expIrq()));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog R1 actual=timeout expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    chk("R1", 32'(irqOut), 32'd0);
    checkAll("R1");

    // R2: all strobes at once; low seven bits must stay clear.
    doCycle(1'b0, 0, '0, 32'hFFFF_FFFF, '0, "R2");
    checkRead(0, "R2");
    // R3: clear bits 8..11 only; data bits 6..0 clear no event bit.
    doCycle(1'b1, 0, 32'h0000_0F3F, '0, '0, "R3");
    checkRead(0, "R3");
    // R4: clear of bit 9 collides with an event on bit 9.
    doCycle(1'b0, 0, '0, 32'h0000_0200, '0, "R4");
    doCycle(1'b1, 0, 32'h0000_0200, 32'h0000_0200, '0, "R4");
    checkRead(0, "R4");
    doCycle(1'b1, 0, 32'hFFFF_FF80, '0, '0, "R3");
    checkRead(0, "R3");

    // R5, R6: channels 3, 40 and 63.
    doCycle(1'b0, 0, '0, '0, (64'd1 << 3) | (64'd1 << 40) | (64'd1 << 63), "R5");
    checkRead(0, "R5");
    doCycle(1'b1, 0, 32'h0000_007F, '0, '0, "R6");
    checkRead(0, "R6");
    checkRead(5, "R6");
    doCycle(1'b1, 5, 32'h0000_0100, '0, '0, "R7");
    checkRead(0, "R5");
    doCycle(1'b1, 0, 32'h0000_0043, '0, 64'd1 << 3, "R4");
    checkRead(0, "R4");
    doCycle(1'b1, 0, 32'h0000_0043, '0, '0, "R6");
    checkRead(0, "R5");

    // R8: unmapped pending bits raise nothing even with enables on.
    doCycle(1'b1, 1, 32'hFFEF_FFFF, '0, '0, "R8");
    doCycle(1'b0, 0, '0, 32'hFE40_0000, '0, "R8");
    chk("R8", 32'(irqOut), 32'd0);
    doCycle(1'b0, 0, '0, 32'h0000_0200, '0, "R8");
    chk("R8", 32'(irqOut), 32'd1);
    doCycle(1'b1, 0, 32'hFFFF_FF80, '0, '0, "R8");
    doCycle(1'b0, 0, '0, '0, 64'd1 << 37, "R8");
    chk("R8", 32'(irqOut), 32'd0);
    doCycle(1'b1, 3, 32'h0000_0020, '0, '0, "R8");
    chk("R8", 32'(irqOut), 32'd1);
    doCycle(1'b1, 5, 32'hFFFF_FFFF, '0, '0, "R8");
    chk("R8", 32'(irqOut), 32'd0);

    // R9: force bit with nothing pending.
    doCycle(1'b1, 1, 32'h0010_0000, '0, '0, "R9");
    chk("R9", 32'(irqOut), 32'd1);
    // R7: addresses 6 and 7 ignore writes.
    doCycle(1'b1, 6, 32'hFFFF_FFFF, '0, '0, "R7");
    doCycle(1'b1, 7, 32'hFFFF_FFFF, '0, '0, "R7");
    checkAll("R7");
    doCycle(1'b1, 1, 32'h0000_0000, '0, '0, "R9");
    chk("R9", 32'(irqOut), 32'd0);

    // R10: random traffic against the model.
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] wd = $urandom;
      logic [31:0] ev = $urandom & $urandom & $urandom;
      logic [63:0] lp = {$urandom & $urandom & $urandom & $urandom,
                         $urandom & $urandom & $urandom & $urandom};
      int a = int'($urandom % 8);
      logic we = ($urandom % 10) < 4;
      if (a == 1 && ($urandom % 8) != 0) wd[20] = 1'b0;
      if (a == 0 && ($urandom % 2) == 0) wd[6] = 1'b1;
      doCycle(we, a, wd, ev, lp, "R8");
      checkRead(int'($urandom % 8), "R10");
    end
    checkAll("R10");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule